// File: doc/BRIEF.md
# Inter-Processor Message Destination Matcher

This block decides whether one local interrupt controller is a target of an inter-processor message. Each message carries a destination field, a destination mode bit (physical or logical), a two-bit shorthand code and a flag that is set when this controller sent the message. The block compares these fields with its own identity. That identity is an 8-bit controller ID, a logical destination word and a 4-bit format selector that picks flat or cluster logical addressing. An extended mode switches logical matching to a full 32-bit comparison. When extended mode is entered, the block computes the logical word from the controller ID.

Messages enter on a valid/ready port. Each accepted message produces exactly one result beat on a valid/ready output in the following cycle. The result holds a match bit and a format-error bit. A message is accepted on a clock edge where `msg_valid` and `msg_ready` are both high. `msg_ready` is high when the result stage is empty or when its current result is being taken in the same cycle (`res_ready` high). While a result waits with `res_ready` low, the result stays unchanged and no new message is accepted.

Configuration is written through a plain write strobe. It is not a stream. Each message is judged with the configuration held before the clock edge that accepts it.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset, `res_valid` is 0 and `msg_ready` is 1. The controller ID is `RESET_ID` (default 0), the logical word is 0, the format selector is flat (4'hF) and extended mode is off.
- R2: The shorthand `msg_short` decides the match as follows:
  - 2'b01 (self): the match equals `msg_from_self`.
  - 2'b10 (everyone): the match is always 1.
  - 2'b11 (everyone else): the match equals NOT `msg_from_self`.
  - 2'b00: no shorthand; the destination is decoded.
- R3: With no shorthand and `msg_logical`=0, the match is 1 exactly when `msg_dest[7:0]` is 8'hFF or equals the controller ID. Bits 31:8 of the destination are ignored.
- R4: In flat format (selector 4'hF) outside extended mode, a logical no-shorthand message matches when bits 31:24 of the logical word ANDed with `msg_dest[7:0]` are nonzero.
- R5: In cluster format (selector 4'h0) outside extended mode, a logical no-shorthand message matches when:
  - bits 31:28 of the logical word equal `msg_dest[7:4]`, and
  - bits 27:24 of the logical word ANDed with `msg_dest[3:0]` are nonzero.
- R6: Outside extended mode, a logical no-shorthand message with any other selector value gives match 0 and `res_fmt_err` 1. Every other result has `res_fmt_err` 0.
- R7: In extended mode, a logical no-shorthand message matches when the 32-bit logical word ANDed with `msg_dest` is nonzero. Extended mode means `ext_mode` was high at the previous clock edge.
- R8: On the first edge where `ext_mode` is high after being low, the logical word is loaded with ((ID AND 8'hF0) << 16) OR (1 << ID[3:0]).
- R9: Configuration writes use `cfg_sel` as follows:
  - 2'd0 writes the ID from `cfg_wdata[31:24]`.
  - 2'd1 writes the full logical word.
  - 2'd2 writes the format selector from `cfg_wdata[31:28]`; bits 27:0 of the format word are always ones.
  - 2'd3 has no effect.
- R10: Configuration writes are ignored in any cycle where `ext_mode` is high.
- R11: A message accepted at an edge gives `res_valid`=1 after that edge, carrying its verdict. While `res_valid` is 1 and `res_ready` is 0, the result is held and `msg_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 ID, 1 logical word, 2 format, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| ext_mode | input | 1 | Extended addressing mode request |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Message accepted when high together with `msg_valid` |
| msg_dest | input | 32 | Message destination field |
| msg_logical | input | 1 | 1 = logical destination, 0 = physical destination |
| msg_short | input | 2 | Shorthand code |
| msg_from_self | input | 1 | Message was sent by this controller |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer ready |
| res_match | output | 1 | This controller is a target |
| res_fmt_err | output | 1 | Unsupported format selector was used |

## Verification
Wrong stored state shows up in the verdict of the next message that consults it. A corrupted ID fails physical matches, a corrupted logical word or selector fails flat, cluster or extended matches, and a wrong mode flag picks the wrong comparison. The error is visible in the result one cycle after that message is accepted. A fault in the result register shows as a lost, duplicated or changed beat while the consumer stalls, or as `msg_ready` disagreeing with the stall state in the same cycle. The bench runs a behavioural model every clock and catches each of these on the first affected cycle.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;
  localparam int FMT_W = 4;
  localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef enum logic [1:0] {
    CFG_ID   = 2'd0,
    CFG_LDR  = 2'd1,
    CFG_FMT  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic match;
    logic fmt_err;
  } verdict_t;
endpackage

// File: rtl/ipi_dest_cfg.sv
module ipi_dest_cfg
  import ipi_match_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8,
  parameter logic [ID_W-1:0] RESET_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ext_mode,
  output logic [ID_W-1:0]   id_q,
  output logic [REG_W-1:0]  ldr_q,
  output logic [FMT_W-1:0]  fmt_q,
  output logic              ext_q
);
  localparam int NIB      = ID_W / 2;
  localparam int CL_SHIFT = REG_W / 2;

  logic [REG_W-1:0] entry_ldr;
  logic             entering;

  assign entering  = ext_mode && !ext_q;
  assign entry_ldr = (REG_W'({id_q[ID_W-1:NIB], {NIB{1'b0}}}) << CL_SHIFT)
                   | (REG_W'(1) << id_q[NIB-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= RESET_ID;
      ldr_q <= '0;
      fmt_q <= FMT_FLAT;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_mode;
      if (entering) begin
        ldr_q <= entry_ldr;
      end else if (we && !ext_mode) begin
        unique case (cfg_sel_e'(sel))
          CFG_ID:  id_q  <= wdata[REG_W-1 -: ID_W];
          CFG_LDR: ldr_q <= wdata;
          CFG_FMT: fmt_q <= wdata[REG_W-1 -: FMT_W];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
  import ipi_match_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8
) (
  input  logic [REG_W-1:0] dest,
  input  logic             logical,
  input  logic [1:0]       short_code,
  input  logic             from_self,
  input  logic [ID_W-1:0]  id,
  input  logic [REG_W-1:0] ldr,
  input  logic [FMT_W-1:0] fmt,
  input  logic             ext,
  output verdict_t         verdict
);
  localparam int NIB = ID_W / 2;

  logic [ID_W-1:0] dest_lo;
  logic [ID_W-1:0] ldr_hi;
  logic phys_hit, flat_hit, cluster_hit, ext_hit;

  assign dest_lo     = dest[ID_W-1:0];
  assign ldr_hi      = ldr[REG_W-1 -: ID_W];
  assign phys_hit    = (dest_lo == {ID_W{1'b1}}) || (dest_lo == id);
  assign flat_hit    = |(ldr_hi & dest_lo);
  assign cluster_hit = (ldr_hi[ID_W-1:NIB] == dest_lo[ID_W-1:NIB])
                    && |(ldr_hi[NIB-1:0] & dest_lo[NIB-1:0]);
  assign ext_hit     = |(ldr & dest);

  always_comb begin
    verdict = '0;
    unique case (short_e'(short_code))
      SH_SELF:   verdict.match = from_self;
      SH_ALL:    verdict.match = 1'b1;
      SH_OTHERS: verdict.match = !from_self;
      default: begin
        if (!logical)            verdict.match = phys_hit;
        else if (ext)            verdict.match = ext_hit;
        else if (fmt == FMT_FLAT)    verdict.match = flat_hit;
        else if (fmt == FMT_CLUSTER) verdict.match = cluster_hit;
        else                     verdict.fmt_err = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ipi_dest_pipe.sv
module ipi_dest_pipe
  import ipi_match_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  verdict_t in_v,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t out_v
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_v     <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_v     <= in_v;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_match_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8,
  parameter logic [ID_W-1:0] RESET_ID = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             ext_mode,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [REG_W-1:0] msg_dest,
  input  logic             msg_logical,
  input  logic [1:0]       msg_short,
  input  logic             msg_from_self,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_match,
  output logic             res_fmt_err
);
  logic [ID_W-1:0]  id_q;
  logic [REG_W-1:0] ldr_q;
  logic [FMT_W-1:0] fmt_q;
  logic             ext_q;
  verdict_t         v_now, v_out;

  ipi_dest_cfg #(.REG_W(REG_W), .ID_W(ID_W), .RESET_ID(RESET_ID)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .ext_mode(ext_mode), .id_q(id_q), .ldr_q(ldr_q), .fmt_q(fmt_q), .ext_q(ext_q)
  );

  ipi_dest_decode #(.REG_W(REG_W), .ID_W(ID_W)) u_dec (
    .dest(msg_dest), .logical(msg_logical), .short_code(msg_short),
    .from_self(msg_from_self), .id(id_q), .ldr(ldr_q), .fmt(fmt_q),
    .ext(ext_q), .verdict(v_now)
  );

  ipi_dest_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(msg_valid), .in_ready(msg_ready),
    .in_v(v_now), .out_valid(res_valid), .out_ready(res_ready), .out_v(v_out)
  );

  assign res_match   = v_out.match;
  assign res_fmt_err = v_out.fmt_err;
endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk #(
  parameter int REG_W = 32,
  parameter int ID_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [REG_W-1:0] msg_dest,
  input logic             msg_logical,
  input logic [1:0]       msg_short,
  input logic             msg_from_self,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_match,
  input logic             res_fmt_err
);
  logic acc;
  assign acc = msg_valid && msg_ready;

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> res_valid); // R11
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ready) |=> (res_valid && $stable(res_match) && $stable(res_fmt_err))); // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ready) |-> !msg_ready); // R11
  AST_ALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (acc && msg_short == 2'b10) |=> res_match); // R2
  AST_OTHERS_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n) (acc && msg_short == 2'b11 && msg_from_self) |=> !res_match); // R2
  AST_PHYS_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n) (acc && msg_short == 2'b00 && !msg_logical && msg_dest[ID_W-1:0] == {ID_W{1'b1}}) |=> res_match); // R3
  AST_ERR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n) (acc && (msg_short != 2'b00 || !msg_logical)) |=> !res_fmt_err); // R6
  AST_ERR_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_fmt_err) |-> !res_match); // R6
endmodule

bind ipi_dest_match ipi_dest_match_chk #(.REG_W(REG_W), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_short(msg_short),
  .msg_from_self(msg_from_self), .res_valid(res_valid), .res_ready(res_ready),
  .res_match(res_match), .res_fmt_err(res_fmt_err)
);

// File: tb/ipi_dest_match_tb_top.sv
module ipi_dest_match_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic ext_mode = 1'b0;
  logic msg_valid = 1'b0;
  logic msg_ready;
  logic [31:0] msg_dest = '0;
  logic msg_logical = 1'b0;
  logic [1:0] msg_short = 2'b00;
  logic msg_from_self = 1'b0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic res_match;
  logic res_fmt_err;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dest_match dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_mode(ext_mode), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_logical(msg_logical),
    .msg_short(msg_short), .msg_from_self(msg_from_self), .res_valid(res_valid),
    .res_ready(res_ready), .res_match(res_match), .res_fmt_err(res_fmt_err)
  );

  // Behavioural reference state
  logic [7:0]  m_id;
  logic [31:0] m_ldr;
  logic [3:0]  m_fmt;
  logic        m_ext;
  logic        m_valid, m_match, m_err;

  function automatic logic [1:0] ref_verdict(input logic [31:0] d, input logic lg,
                                             input logic [1:0] sh, input logic sf);
    logic m = 1'b0;
    logic e = 1'b0;
    if (sh == 2'd1) m = sf;
    else if (sh == 2'd2) m = 1'b1;
    else if (sh == 2'd3) m = !sf;
    else if (!lg) m = (d[7:0] == 8'd255) || (d[7:0] == m_id);
    else if (m_ext) m = ((m_ldr & d) != 0);
    else if (m_fmt == 4'd15) m = ((m_ldr[31:24] & d[7:0]) != 0);
    else if (m_fmt == 4'd0) m = (m_ldr[31:28] == d[7:4]) && ((m_ldr[27:24] & d[3:0]) != 0);
    else e = 1'b1;
    return {m, e};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_id = 8'd0; m_ldr = 32'd0; m_fmt = 4'hF; m_ext = 1'b0;
      m_valid = 1'b0; m_match = 1'b0; m_err = 1'b0;
    end else begin
      logic [1:0] v;
      if (msg_valid && (!m_valid || res_ready)) begin
        v = ref_verdict(msg_dest, msg_logical, msg_short, msg_from_self);
        m_valid = 1'b1; m_match = v[1]; m_err = v[0];
      end else if (res_ready) begin
        m_valid = 1'b0;
      end
      if (ext_mode && !m_ext)
        m_ldr = ({24'd0, m_id & 8'hF0} << 16) | (32'd1 << m_id[3:0]);
      else if (cfg_we && !ext_mode) begin
        if (cfg_sel == 2'd0) m_id = cfg_wdata[31:24];
        else if (cfg_sel == 2'd1) m_ldr = cfg_wdata;
        else if (cfg_sel == 2'd2) m_fmt = cfg_wdata[31:28];
      end
      m_ext = ext_mode;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] act, exp;
      act = {msg_ready, res_valid, res_valid & res_match, res_valid & res_fmt_err};
      exp = {!m_valid || res_ready, m_valid, m_valid & m_match, m_valid & m_err};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model compare: got %b expected %b (ready,valid,match,err)", cur_req, act, exp);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_ext(input logic v);
    @(posedge clk); #1;
    ext_mode = v;
    @(posedge clk); #1;
  endtask

  task automatic send(input string req, input logic [31:0] d, input logic lg,
                      input logic [1:0] sh, input logic sf,
                      input logic exp_m, input logic exp_e);
    cur_req = req;
    @(posedge clk); #1;
    msg_valid = 1'b1; msg_dest = d; msg_logical = lg; msg_short = sh; msg_from_self = sf;
    @(posedge clk); #1;
    msg_valid = 1'b0;
    @(negedge clk);
    chk(req, {30'd0, res_valid, res_match}, {30'd0, 1'b1, exp_m});
    chk(req, {31'd0, res_fmt_err}, {31'd0, exp_e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {30'd0, res_valid, msg_ready}, {30'd0, 1'b0, 1'b1});
    send("R1", 32'h0000_0000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R1", 32'h0000_00FF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    // R2 shorthand codes
    send("R2", 32'h0000_0055, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0);
    send("R2", 32'h0000_0055, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
    send("R2", 32'h0000_0055, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0);
    send("R2", 32'h0000_0055, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
    send("R2", 32'h0000_0055, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0);

    // R3 physical addressing, R9 ID write
    cfg_write(2'd0, 32'h2A00_0000);
    send("R3", 32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R3", 32'h0000_002B, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    send("R3", 32'h0000_00FF, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R3", 32'h1234_562A, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);

    // R4 flat logical
    cfg_write(2'd1, 32'h0500_0000);
    send("R4", 32'h0000_0004, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R4", 32'h0000_000A, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    send("R4", 32'h0000_0001, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);

    // R5 cluster logical, R9 format write forces low bits
    cfg_write(2'd2, 32'h0000_0000);
    cfg_write(2'd1, 32'h3500_0000);
    send("R5", 32'h0000_0031, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R5", 32'h0000_0034, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R5", 32'h0000_0032, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    send("R5", 32'h0000_0045, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    // R6 unsupported format, R9 selector field position
    cfg_write(2'd2, 32'h5123_4567);
    send("R6", 32'h0000_0035, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
    send("R6", 32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R6", 32'h0000_0035, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0);
    cfg_write(2'd3, 32'h0000_0000);
    send("R9", 32'h0000_0035, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
    cfg_write(2'd2, 32'hF000_0000);
    send("R9", 32'h0000_0001, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);

    // R8 entry derivation (ID 0x2A -> 0x0020_0400), R7 extended logical
    cur_req = "R8";
    set_ext(1'b1);
    send("R8", 32'h0000_0400, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R8", 32'h0020_0000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R7", 32'h0000_0800, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    send("R7", 32'hFFFF_FBFF, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R7", 32'hFFDF_FBFF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    // R10 writes ignored while extended mode is requested
    cur_req = "R10";
    cfg_write(2'd2, 32'h1000_0000);
    cfg_write(2'd0, 32'h7700_0000);
    cfg_write(2'd1, 32'hFF00_0000);
    send("R10", 32'h0000_0400, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0);
    send("R10", 32'h0000_002A, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    set_ext(1'b0);
    send("R10", 32'h0000_00FF, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    send("R10", 32'h0000_0077, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);

    // R11 stall and release
    cur_req = "R11";
    @(posedge clk); #1;
    res_ready = 1'b0;
    msg_valid = 1'b1; msg_dest = '0; msg_logical = 1'b0; msg_short = 2'b10; msg_from_self = 1'b0;
    @(posedge clk); #1;
    msg_short = 2'b01;
    @(negedge clk);
    chk("R11", {29'd0, res_valid, res_match, msg_ready}, {29'd0, 3'b110});
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11", {29'd0, res_valid, res_match, msg_ready}, {29'd0, 3'b110});
    @(posedge clk); #1;
    res_ready = 1'b1;
    @(negedge clk);
    chk("R11", {31'd0, msg_ready}, 32'd1);
    @(posedge clk); #1;
    msg_valid = 1'b0;
    @(negedge clk);
    chk("R11", {30'd0, res_valid, res_match}, {30'd0, 2'b10});
    // back-to-back stream
    @(posedge clk); #1;
    msg_valid = 1'b1; msg_short = 2'b10;
    repeat (4) @(posedge clk);
    #1 msg_valid = 1'b0;
    repeat (3) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule